// File: doc/BRIEF.md
# Output Fault Protection Sequencer

This block decides, cycle by cycle, whether the power output of a supply channel may be switched on. It watches three fault comparators (overcurrent, reverse current flowing back into the output, and over-temperature) and runs a set of millisecond timers against them. A millisecond strobe paces every window, so the same logic serves any system clock.

In dynamic current-limit mode a sustained overcurrent starts a hiccup. The output is cut for a long off window and then comes back through a soft-start. In static mode the output stays on, and an overload flag records that the clamp was reached. A sustained reverse current runs its own shorter on/off cycle. Every over-temperature event shuts the output until the comparator clears. The events are counted, and the last allowed one latches the block off until the enable bit is taken low and high again.

The status flags drive a register readback elsewhere. An active-low fault line, which also carries the supply-undervoltage and register-reset conditions, serves as the processor interrupt.

Top module: `outFaultSeq`

## Requirements
- R1: While `enable` is low the output is off, all timers, the event counter and the flags are cleared, and the next cycle after `enable` goes high starts a soft-start (`softStart` high).
- R2: A soft-start keeps `outEn` and `softStart` high for `SS_MS` ticks of `msTick`, then enters normal running (`softStart` low, `outEn` high).
- R3: In dynamic mode (`dynMode` = 1), `ocDet` held during `OC_ON_MS` consecutive ticks cuts the output for `OC_OFF_MS` ticks with `olFlag` high, then a soft-start follows. If `ocDet` drops before the window completes, the timer restarts from zero.
- R4: In static mode (`dynMode` = 0) an overcurrent never cuts the output. `olFlag` goes high while the clamp is hit and returns low at the end of the next soft-start, or when `enable` goes low.
- R5: `bcDet` held during `BC_ON_MS` ticks cuts the output for `BC_OFF_MS` ticks with `bcFlag` high. The output then returns straight to running, and the cycle repeats while the fault remains.
- R6: `otDet` seen while the output is on or in a current-fault off window cuts the output with `otFlag` high. The output stays off while `otDet` stays high, and a soft-start begins the cycle after it clears.
- R7: The `OT_EVENTS`-th over-temperature event latches the block off with `otFlag` high, whatever `otDet` does afterwards. Only a low phase on `enable` or reset releases it.
- R8: Faults reaching their trip point in the same cycle resolve thermal first, then reverse current, then overcurrent.
- R9: `faultN` is low exactly when `otFlag`, `olFlag`, `uvloDet` or `regReset` is high.
- R10: After reset the output is off, all flags are low and `faultN` follows only `uvloDet` and `regReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle strobe every millisecond |
| enable | input | 1 | Channel enable control bit |
| dynMode | input | 1 | 1 = dynamic hiccup limiting, 0 = static clamp |
| ocDet | input | 1 | Overcurrent comparator |
| bcDet | input | 1 | Reverse-current comparator |
| otDet | input | 1 | Over-temperature comparator |
| uvloDet | input | 1 | Supply undervoltage indication |
| regReset | input | 1 | Register reset condition indication |
| outEn | output | 1 | Power output enable |
| softStart | output | 1 | Soft-start in progress |
| olFlag | output | 1 | Overload status flag |
| bcFlag | output | 1 | Reverse-current fault flag |
| otFlag | output | 1 | Over-temperature flag |
| faultN | output | 1 | Active-low fault interrupt |

## Verification
The bench builds the sequencer with short windows: a 4-tick soft-start, a 2-tick overcurrent window with a 6-tick off time, and a 2-tick reverse-current window with a 5-tick off time. `msTick` fires every third clock. These windows let several full hiccup cycles, repeated reverse-current cycles and all four thermal events to the latch fit in a few thousand clocks. Because the overcurrent and reverse-current windows are equal, both trip in the same cycle, which makes the priority order observable. The four-event latch count stays at its default, so the latch is reached through the real counting path.

// File: rtl/outFaultSeq_pkg.sv
package outFaultSeq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SOFT, ST_RUN, ST_OCOFF, ST_BCOFF, ST_OTOFF, ST_OTLATCH
  } seqState_t;

  typedef enum logic [1:0] {PH_SOFT, PH_OC, PH_BC} phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      clrPhase;
    phaseSel_t phaseSel;
    logic      ocArm;
    logic      bcArm;
    logic      otInc;
    logic      flush;
    logic      olSet;
    logic      olClr;
  } seqCtl_t;

endpackage

// File: rtl/outFaultSeq_dp.sv
module outFaultSeq_dp
  import outFaultSeq_pkg::*;
#(
  parameter int SS_MS     = 20,
  parameter int OC_ON_MS  = 51,
  parameter int OC_OFF_MS = 900,
  parameter int BC_ON_MS  = 2,
  parameter int BC_OFF_MS = 50,
  parameter int OT_EVENTS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    msTick,
  input  logic    ocDet,
  input  logic    bcDet,
  input  seqCtl_t ctl,
  output logic    phaseDone,
  output logic    ocTrip,
  output logic    bcTrip,
  output logic    otLast,
  output logic    staticOl
);

  localparam int PH_MAX = (SS_MS > OC_OFF_MS) ?
                          ((SS_MS > BC_OFF_MS) ? SS_MS : BC_OFF_MS) :
                          ((OC_OFF_MS > BC_OFF_MS) ? OC_OFF_MS : BC_OFF_MS);
  localparam int PH_W = $clog2(PH_MAX + 1);
  localparam int OC_W = $clog2(OC_ON_MS + 1);
  localparam int BC_W = $clog2(BC_ON_MS + 1);
  localparam int OT_W = $clog2(OT_EVENTS + 1);

  logic [PH_W-1:0] phaseCnt, phaseLim;
  logic [OC_W-1:0] ocCnt;
  logic [BC_W-1:0] bcCnt;
  logic [OT_W-1:0] otCnt;

  always_comb begin
    unique case (ctl.phaseSel)
      PH_OC:   phaseLim = PH_W'(OC_OFF_MS);
      PH_BC:   phaseLim = PH_W'(BC_OFF_MS);
      default: phaseLim = PH_W'(SS_MS);
    endcase
  end

  assign phaseDone = msTick && (phaseCnt == phaseLim - 1'b1);
  assign ocTrip    = ctl.ocArm && ocDet && msTick && (ocCnt == OC_W'(OC_ON_MS - 1));
  assign bcTrip    = ctl.bcArm && bcDet && msTick && (bcCnt == BC_W'(BC_ON_MS - 1));
  assign otLast    = (otCnt == OT_W'(OT_EVENTS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      ocCnt    <= '0;
      bcCnt    <= '0;
      otCnt    <= '0;
      staticOl <= 1'b0;
    end else begin
      if (ctl.clrPhase)      phaseCnt <= '0;
      else if (msTick)       phaseCnt <= phaseCnt + 1'b1;

      if (!ctl.ocArm || !ocDet) ocCnt <= '0;
      else if (msTick)          ocCnt <= ocCnt + 1'b1;

      if (!ctl.bcArm || !bcDet) bcCnt <= '0;
      else if (msTick)          bcCnt <= bcCnt + 1'b1;

      if (ctl.flush)         otCnt <= '0;
      else if (ctl.otInc)    otCnt <= otCnt + 1'b1;

      if (ctl.flush)         staticOl <= 1'b0;
      else if (ctl.olSet)    staticOl <= 1'b1;
      else if (ctl.olClr)    staticOl <= 1'b0;
    end
  end

  a_r3_oc_bound: assert property (@(posedge clk) disable iff (!rstN)
    ocCnt <= OC_W'(OC_ON_MS));
  a_r5_bc_bound: assert property (@(posedge clk) disable iff (!rstN)
    bcCnt <= BC_W'(BC_ON_MS));
  a_r7_ot_bound: assert property (@(posedge clk) disable iff (!rstN)
    otCnt <= OT_W'(OT_EVENTS));
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= PH_W'(PH_MAX));

endmodule

// File: rtl/outFaultSeq_ctl.sv
module outFaultSeq_ctl
  import outFaultSeq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      dynMode,
  input  logic      ocDet,
  input  logic      otDet,
  input  logic      phaseDone,
  input  logic      ocTrip,
  input  logic      bcTrip,
  input  logic      otLast,
  output seqCtl_t   ctl,
  output seqState_t state
);

  seqState_t nxt;
  logic active, onOrCurOff;

  assign active     = (state == ST_SOFT) || (state == ST_RUN);
  assign onOrCurOff = active || (state == ST_OCOFF) || (state == ST_BCOFF);

  always_comb begin
    nxt = state;
    if (!enable) nxt = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:    nxt = ST_SOFT;
        ST_OTLATCH: nxt = ST_OTLATCH;
        ST_OTOFF:   if (!otDet) nxt = ST_SOFT;
        default: begin
          if (otDet)                           nxt = otLast ? ST_OTLATCH : ST_OTOFF;
          else if (state == ST_BCOFF)          begin if (phaseDone) nxt = ST_RUN;  end
          else if (state == ST_OCOFF)          begin if (phaseDone) nxt = ST_SOFT; end
          else if (bcTrip)                     nxt = ST_BCOFF;
          else if (ocTrip)                     nxt = ST_OCOFF;
          else if (state == ST_SOFT && phaseDone) nxt = ST_RUN;
        end
      endcase
    end
  end

  always_comb begin
    ctl.clrPhase = (nxt != state) ||
                   !((state == ST_SOFT) || (state == ST_OCOFF) || (state == ST_BCOFF));
    unique case (state)
      ST_OCOFF: ctl.phaseSel = PH_OC;
      ST_BCOFF: ctl.phaseSel = PH_BC;
      default:  ctl.phaseSel = PH_SOFT;
    endcase
    ctl.ocArm = active && dynMode;
    ctl.bcArm = active;
    ctl.otInc = enable && otDet && onOrCurOff;
    ctl.flush = !enable;
    ctl.olSet = enable && active && ocDet && !dynMode;
    ctl.olClr = (state == ST_SOFT) && phaseDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  a_r1_disable: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE));
  a_r6_recover: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_OTOFF && !otDet) |=> (state == ST_SOFT));
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_OTLATCH) |=> (state == ST_OTLATCH || $past(!enable) || !enable || state == ST_IDLE));
  a_r8_ot_first: assert property (@(posedge clk) disable iff (!rstN)
    (enable && onOrCurOff && otDet) |=> (state == ST_OTOFF || state == ST_OTLATCH));
  a_r8_bc_over_oc: assert property (@(posedge clk) disable iff (!rstN)
    (enable && active && !otDet && bcTrip && ocTrip) |=> (state == ST_BCOFF));

endmodule

// File: rtl/outFaultSeq.sv
module outFaultSeq
  import outFaultSeq_pkg::*;
#(
  parameter int SS_MS     = 20,
  parameter int OC_ON_MS  = 51,
  parameter int OC_OFF_MS = 900,
  parameter int BC_ON_MS  = 2,
  parameter int BC_OFF_MS = 50,
  parameter int OT_EVENTS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic enable,
  input  logic dynMode,
  input  logic ocDet,
  input  logic bcDet,
  input  logic otDet,
  input  logic uvloDet,
  input  logic regReset,
  output logic outEn,
  output logic softStart,
  output logic olFlag,
  output logic bcFlag,
  output logic otFlag,
  output logic faultN
);

  seqCtl_t   ctl;
  seqState_t state;
  logic phaseDone, ocTrip, bcTrip, otLast, staticOl;

  outFaultSeq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .dynMode(dynMode),
    .ocDet(ocDet), .otDet(otDet), .phaseDone(phaseDone), .ocTrip(ocTrip),
    .bcTrip(bcTrip), .otLast(otLast), .ctl(ctl), .state(state)
  );

  outFaultSeq_dp #(
    .SS_MS(SS_MS), .OC_ON_MS(OC_ON_MS), .OC_OFF_MS(OC_OFF_MS),
    .BC_ON_MS(BC_ON_MS), .BC_OFF_MS(BC_OFF_MS), .OT_EVENTS(OT_EVENTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ocDet(ocDet), .bcDet(bcDet),
    .ctl(ctl), .phaseDone(phaseDone), .ocTrip(ocTrip), .bcTrip(bcTrip),
    .otLast(otLast), .staticOl(staticOl)
  );

  assign outEn     = (state == ST_SOFT) || (state == ST_RUN);
  assign softStart = (state == ST_SOFT);
  assign bcFlag    = (state == ST_BCOFF);
  assign otFlag    = (state == ST_OTOFF) || (state == ST_OTLATCH);
  assign olFlag    = staticOl || (state == ST_OCOFF);
  assign faultN    = !(otFlag || olFlag || uvloDet || regReset);

  a_r4_static_stays_on: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !dynMode && outEn && !otDet && !bcDet) |=> (outEn || !enable || $past(!enable)));
  a_r5_bc_cuts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bcFlag) |-> $past(outEn));

endmodule

// File: tb/outFaultSeq_bench.sv
module outFaultSeq_bench;

  localparam int SS = 4, OCON = 2, OCOFF = 6, BCON = 2, BCOFF = 5, OTN = 4;
  localparam int S_IDLE = 0, S_SOFT = 1, S_RUN = 2, S_OCOFF = 3, S_BCOFF = 4,
                 S_OTOFF = 5, S_LATCH = 6;

  logic clk = 0, rstN = 0, msTick = 0, enable = 0, dynMode = 1;
  logic ocDet = 0, bcDet = 0, otDet = 0, uvloDet = 0, regReset = 0;
  logic outEn, softStart, olFlag, bcFlag, otFlag, faultN;

  int checks = 0, fails = 0, tickDiv = 0;
  bit done = 0;
  string curReq = "R10";

  int mSt = 0, mPh = 0, mOc = 0, mBc = 0, mOt = 0; bit mOl = 0;
  int nSt, nPh, nOc, nBc, nOt; bit nOl, act, ssEnd, bTrip, oTrip;

  always #4 clk = ~clk;

  outFaultSeq #(.SS_MS(SS), .OC_ON_MS(OCON), .OC_OFF_MS(OCOFF),
                .BC_ON_MS(BCON), .BC_OFF_MS(BCOFF), .OT_EVENTS(OTN)) u_outFaultSeq (
    .clk(clk), .rstN(rstN), .msTick(msTick), .enable(enable), .dynMode(dynMode),
    .ocDet(ocDet), .bcDet(bcDet), .otDet(otDet), .uvloDet(uvloDet), .regReset(regReset),
    .outEn(outEn), .softStart(softStart), .olFlag(olFlag), .bcFlag(bcFlag),
    .otFlag(otFlag), .faultN(faultN));

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mSt = S_IDLE; mPh = 0; mOc = 0; mBc = 0; mOt = 0; mOl = 0;
    end else begin
      nSt = mSt; nPh = mPh; nOc = 0; nBc = 0; nOt = mOt; nOl = mOl;
      act   = (mSt == S_SOFT) || (mSt == S_RUN);
      ssEnd = (mSt == S_SOFT) && msTick && (mPh == SS - 1);
      if (!enable) begin
        nSt = S_IDLE; nPh = 0; nOt = 0; nOl = 0;
      end else begin
        if (act) begin
          if (ocDet && !dynMode) nOl = 1; else if (ssEnd) nOl = 0;
        end
        case (mSt)
          S_IDLE:  begin nSt = S_SOFT; nPh = 0; end
          S_LATCH: ;
          S_OTOFF: if (!otDet) begin nSt = S_SOFT; nPh = 0; end
          default: begin
            if (otDet) begin
              nOt = mOt + 1; nSt = (nOt == OTN) ? S_LATCH : S_OTOFF; nPh = 0;
            end else if (mSt == S_BCOFF || mSt == S_OCOFF) begin
              if (msTick) begin
                if (mPh == ((mSt == S_BCOFF) ? BCOFF : OCOFF) - 1) begin
                  nSt = (mSt == S_BCOFF) ? S_RUN : S_SOFT; nPh = 0;
                end else nPh = mPh + 1;
              end
            end else begin
              bTrip = bcDet && msTick && (mBc == BCON - 1);
              oTrip = dynMode && ocDet && msTick && (mOc == OCON - 1);
              nBc = bcDet ? mBc + (msTick ? 1 : 0) : 0;
              nOc = (dynMode && ocDet) ? mOc + (msTick ? 1 : 0) : 0;
              if (bTrip)      begin nSt = S_BCOFF; nPh = 0; nBc = 0; nOc = 0; end
              else if (oTrip) begin nSt = S_OCOFF; nPh = 0; nBc = 0; nOc = 0; end
              else if (ssEnd) begin nSt = S_RUN; nPh = 0; end
              else if (mSt == S_SOFT && msTick) nPh = mPh + 1;
            end
          end
        endcase
      end
      mSt = nSt; mPh = nPh; mOc = nOc; mBc = nBc; mOt = nOt; mOl = nOl;
    end
  end

  task automatic chk(string req, string name, logic act_v, logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison, then tick generation (every third clock)
  always @(negedge clk) begin
    if (rstN) begin
      bit eOt, eOl;
      eOt = (mSt == S_OTOFF) || (mSt == S_LATCH);
      eOl = mOl || (mSt == S_OCOFF);
      chk(curReq, "outEn",     outEn,     (mSt == S_SOFT) || (mSt == S_RUN));
      chk(curReq, "softStart", softStart, mSt == S_SOFT);
      chk(curReq, "olFlag",    olFlag,    eOl);
      chk(curReq, "bcFlag",    bcFlag,    mSt == S_BCOFF);
      chk(curReq, "otFlag",    otFlag,    eOt);
      chk("R9",   "faultN",    faultN,    !(eOt || eOl || uvloDet || regReset));
    end
    tickDiv = (tickDiv == 2) ? 0 : tickDiv + 1;
    msTick  = (tickDiv == 0);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  initial begin
    wait_cyc(3);
    // R10: reset state
    at_neg();
    chk("R10", "outEn",  outEn,  1'b0);
    chk("R10", "otFlag", otFlag, 1'b0);
    chk("R10", "faultN", faultN, 1'b1);
    rstN = 1;
    wait_cyc(2);

    curReq = "R1"; enable = 1; dynMode = 1;
    wait_cyc(1); at_neg();
    chk("R1", "softStart", softStart, 1'b1);
    curReq = "R2"; wait_cyc(20); at_neg();
    chk("R2", "outEn", outEn, 1'b1);
    chk("R2", "softStart", softStart, 1'b0);

    curReq = "R3"; ocDet = 1; wait_cyc(40); ocDet = 0; wait_cyc(25);
    ocDet = 1; wait_cyc(3); ocDet = 0; wait_cyc(3); ocDet = 1; wait_cyc(3); ocDet = 0;
    wait_cyc(10); at_neg();
    chk("R3", "outEn after short pulses", outEn, 1'b1);

    curReq = "R4"; dynMode = 0; ocDet = 1; wait_cyc(30); at_neg();
    chk("R4", "olFlag static", olFlag, 1'b1);
    chk("R4", "outEn static", outEn, 1'b1);
    ocDet = 0; enable = 0; wait_cyc(2);
    enable = 1; wait_cyc(1); ocDet = 1; wait_cyc(2); ocDet = 0; wait_cyc(2); at_neg();
    chk("R4", "olFlag during soft-start", olFlag, 1'b1);
    wait_cyc(20); at_neg();
    chk("R4", "olFlag after soft-start", olFlag, 1'b0);

    curReq = "R5"; dynMode = 1; bcDet = 1; wait_cyc(45); bcDet = 0; wait_cyc(25);

    curReq = "R6"; otDet = 1; wait_cyc(6); at_neg();
    chk("R6", "otFlag", otFlag, 1'b1);
    chk("R6", "outEn", outEn, 1'b0);
    otDet = 0; wait_cyc(2); at_neg();
    chk("R6", "softStart after clear", softStart, 1'b1);
    wait_cyc(20);

    curReq = "R7";
    for (int i = 0; i < 3; i++) begin
      otDet = 1; wait_cyc(5); otDet = 0; wait_cyc(20);
    end
    at_neg();
    chk("R7", "otFlag latched", otFlag, 1'b1);
    chk("R7", "faultN latched", faultN, 1'b0);
    chk("R7", "outEn latched", outEn, 1'b0);
    enable = 0; wait_cyc(2); enable = 1; wait_cyc(2); at_neg();
    chk("R7", "otFlag released", otFlag, 1'b0);
    chk("R1", "softStart after re-enable", softStart, 1'b1);
    wait_cyc(20);

    curReq = "R8"; otDet = 1; bcDet = 1; ocDet = 1; wait_cyc(4); at_neg();
    chk("R8", "otFlag wins", otFlag, 1'b1);
    chk("R8", "bcFlag loses", bcFlag, 1'b0);
    otDet = 0; bcDet = 0; ocDet = 0; wait_cyc(25);
    bcDet = 1; ocDet = 1; wait_cyc(12); bcDet = 0; ocDet = 0; wait_cyc(30);

    curReq = "R9"; uvloDet = 1; wait_cyc(2); at_neg();
    chk("R9", "faultN uvlo", faultN, 1'b0);
    uvloDet = 0; regReset = 1; wait_cyc(2); at_neg();
    chk("R9", "faultN regReset", faultN, 1'b0);
    regReset = 0; wait_cyc(2); at_neg();
    chk("R9", "faultN clear", faultN, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule